// File: doc/BRIEF.md
# Multi-Channel Match PWM Timer

This block is a free-running timer counter with a bank of match registers, and each match register drives one single-edge PWM output. Control bits mark which match registers may restart the counter. The lowest-indexed marked register sets the cycle length: the counter returns to zero on the tick after it equals that value. Every match register drives its own output. The output is LOW before the counter reaches the match value and HIGH from that point to the end of the cycle.

Two counting modes exist. Edge-aligned mode counts up and wraps. Center-aligned mode counts up to the period value and then back down to zero, and it does not repeat either end value. On the downward leg an output falls as soon as the counter is at or below its match value. Match values written while the counter runs are held in a pending copy and take effect at the next cycle start, so an output never glitches within a cycle. Writes made while the counter is stopped take effect on the next clock edge. The control bits take effect on the edge after they are written and should be changed only while the counter is stopped.

Top module: `pwm_match_timer`

## Requirements
- R1: While reset is asserted, and immediately after reset, the counter reads 0 and every PWM output is LOW.
- R2: In edge-aligned mode (`ctrl_center`=0), each clock with `cnt_en`=1 adds one to the counter. On the clock after the counter equals the period value, the counter becomes 0, and that clock starts a new cycle.
- R3: In edge-aligned mode, an output whose match value m is nonzero and not above the period is LOW while the counter is below m. It is HIGH from the count equal to m through the period value, and it is LOW again at the cycle start.
- R4: An output with a match value of 0 stays LOW until the counter first returns to zero. From then on it stays HIGH continuously.
- R5: A match value equal to the period gives a HIGH pulse exactly one tick wide, at the count equal to the period, once per cycle.
- R6: An output whose match value is above the period never goes HIGH. If the output is already HIGH when such a value takes effect, it stays HIGH until the next cycle start, where it goes LOW.
- R7: A match value written while `cnt_en`=1 has no effect until the next cycle start. A value written while `cnt_en`=0 takes effect from the next clock edge.
- R8: The period value is the match value of the lowest-indexed register whose bit in `ctrl_period_mask` is 1. Bit i of the mask belongs to match register i. With no bit set, the counter runs over its full range.
- R9: In center-aligned mode (`ctrl_center`=1), the counter steps 0, 1, …, P, P−1, …, 1, 0, 1, … for period P. Each return to 0 starts a new cycle.
- R10: In center-aligned mode, with a nonzero match value m, an output goes HIGH when the upward count reaches m. It goes LOW on the downward leg once the count is at or below m, and it is LOW at each cycle start.
- R11: While `cnt_en`=0, the counter and all PWM outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release is synchronised inside the block |
| cnt_en | input | 1 | Counter enable |
| match_we | input | 1 | Write strobe for one match register |
| match_sel | input | SEL_W | Index of the match register to write |
| match_data | input | CNT_W | Match value to write |
| ctrl_we | input | 1 | Write strobe for the control bits |
| ctrl_period_mask | input | NUM_MATCH | Per-register bit that allows the register to restart the counter |
| ctrl_center | input | 1 | 1 = center-aligned counting, 0 = edge-aligned counting |
| count_o | output | CNT_W | Current counter value |
| pwm_o | output | NUM_MATCH | PWM outputs, bit i driven by match register i |

## Verification
The counter and the PWM outputs are registers updated on the same enabled rising edge. After the edge where enable rises, the k-th falling edge therefore shows the result of k steps: count, output level and direction turn together. The bench drives every input on a falling edge and samples on the falling edge that follows the k-th rising edge. Its model is indexed by that step count k within the cycle. A match write made while running is modelled as taking over at the step where the count reads 0 again. A write made while stopped is already in force on the next falling edge. Reset clears the registers at once, so its result is checked on the first falling edge while reset is held.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Counting direction of the timer core.
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic sync_q;

  // Reset asserts at once and releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      sync_q  <= stage_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             center,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] tc_q,
  output logic [CNT_W-1:0] tc_nxt,
  output logic             cyc_start,
  output logic             step_down
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cnt_dir_e dir_q;
  cnt_dir_e dir_nxt;

  // Next-state: the count and direction after one enabled tick.
  always_comb begin
    tc_nxt    = tc_q;
    dir_nxt   = dir_q;
    cyc_start = 1'b0;
    step_down = 1'b0;
    if (!center) begin
      dir_nxt = DIR_UP;
      if (tc_q >= period) begin
        tc_nxt    = '0;
        cyc_start = 1'b1;
      end else begin
        tc_nxt = tc_q + ONE;
      end
    end else if (period == '0) begin
      tc_nxt    = '0;
      cyc_start = 1'b1;
      dir_nxt   = DIR_UP;
    end else if ((dir_q == DIR_UP) && (tc_q < period)) begin
      tc_nxt = tc_q + ONE;
    end else begin
      // Turn at the top, or continue down; each end value appears once.
      step_down = 1'b1;
      if (tc_q <= ONE) begin
        tc_nxt    = '0;
        cyc_start = 1'b1;
        dir_nxt   = DIR_UP;
      end else begin
        tc_nxt  = tc_q - ONE;
        dir_nxt = DIR_DOWN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q  <= '0;
      dir_q <= DIR_UP;
    end else if (cnt_en) begin
      tc_q  <= tc_nxt;
      dir_q <= dir_nxt;
    end
  end

endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
  parameter int NUM_MATCH = 4,
  parameter int CNT_W     = 32,
  parameter int SEL_W     = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [SEL_W-1:0]                sel,
  input  logic [CNT_W-1:0]                data,
  input  logic                            load,
  output logic [NUM_MATCH-1:0][CNT_W-1:0] act_q,
  output logic [NUM_MATCH-1:0][CNT_W-1:0] act_nxt
);

  // Each entry has a pending copy written by software and an active copy
  // used for comparison; the active copy follows the pending one on load.
  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_ent
    logic             hit;
    logic [CNT_W-1:0] pend_q;
    logic [CNT_W-1:0] pend_d;
    logic [CNT_W-1:0] act_r;
    logic [CNT_W-1:0] act_d;

    assign hit = we && (sel == SEL_W'(g));

    always_comb begin
      pend_d = hit ? data : pend_q;
      act_d  = load ? pend_d : act_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
        act_r  <= '0;
      end else begin
        pend_q <= pend_d;
        act_r  <= act_d;
      end
    end

    assign act_q[g]   = act_r;
    assign act_nxt[g] = act_d;
  end

endmodule

// File: rtl/pwm_out_chan.sv
module pwm_out_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cyc_start,
  input  logic             step_down,
  input  logic [CNT_W-1:0] tc_nxt,
  input  logic [CNT_W-1:0] match_cur,
  input  logic [CNT_W-1:0] match_nxt,
  output logic             pwm_q
);

  logic pwm_d;

  // Set on reaching the match going up, clear at or below it going down,
  // and start every cycle LOW unless the match value is zero.
  always_comb begin
    pwm_d = pwm_q;
    if (tick) begin
      if (cyc_start) begin
        pwm_d = (match_nxt == '0);
      end else if (step_down) begin
        pwm_d = pwm_q && (tc_nxt > match_cur);
      end else begin
        pwm_d = pwm_q || (tc_nxt == match_cur);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end

endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
  import pwm_timer_pkg::*;
#(
  parameter int NUM_MATCH = 4,
  parameter int CNT_W     = 32,
  localparam int SEL_W    = (NUM_MATCH > 1) ? $clog2(NUM_MATCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_en,
  input  logic                 match_we,
  input  logic [SEL_W-1:0]     match_sel,
  input  logic [CNT_W-1:0]     match_data,
  input  logic                 ctrl_we,
  input  logic [NUM_MATCH-1:0] ctrl_period_mask,
  input  logic                 ctrl_center,
  output logic [CNT_W-1:0]     count_o,
  output logic [NUM_MATCH-1:0] pwm_o
);

  logic                            rst_n_s;
  logic [NUM_MATCH-1:0]            mask_q;
  logic [NUM_MATCH-1:0]            mask_d;
  logic                            center_q;
  logic                            center_d;
  logic [CNT_W-1:0]                period;
  logic [NUM_MATCH-1:0][CNT_W-1:0] act_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] act_nxt;
  logic [CNT_W-1:0]                tc_q;
  logic [CNT_W-1:0]                tc_nxt;
  logic                            cyc_start;
  logic                            step_down;
  logic                            tick_start;
  logic                            load;

  pwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // Control register: next state and storage.
  always_comb begin
    mask_d   = ctrl_we ? ctrl_period_mask : mask_q;
    center_d = ctrl_we ? ctrl_center : center_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mask_q   <= '0;
      center_q <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      center_q <= center_d;
    end
  end

  // Lowest-indexed register with its restart bit set defines the period.
  always_comb begin
    logic found;
    found  = 1'b0;
    period = '1;
    for (int i = 0; i < NUM_MATCH; i++) begin
      if (!found && mask_q[i]) begin
        period = act_q[i];
        found  = 1'b1;
      end
    end
  end

  pwm_count_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cnt_en    (cnt_en),
    .center    (center_q),
    .period    (period),
    .tc_q      (tc_q),
    .tc_nxt    (tc_nxt),
    .cyc_start (cyc_start),
    .step_down (step_down)
  );

  assign tick_start = cnt_en && cyc_start;
  assign load       = !cnt_en || tick_start;

  pwm_match_bank #(
    .NUM_MATCH (NUM_MATCH),
    .CNT_W     (CNT_W),
    .SEL_W     (SEL_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we      (match_we),
    .sel     (match_sel),
    .data    (match_data),
    .load    (load),
    .act_q   (act_q),
    .act_nxt (act_nxt)
  );

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_chan
    pwm_out_chan #(
      .CNT_W (CNT_W)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .tick      (cnt_en),
      .cyc_start (cyc_start),
      .step_down (step_down),
      .tc_nxt    (tc_nxt),
      .match_cur (act_q[g]),
      .match_nxt (act_nxt[g]),
      .pwm_q     (pwm_o[g])
    );
  end

  assign count_o = tc_q;

endmodule

// File: rtl/pwm_match_timer_chk.sv
module pwm_match_timer_chk #(
  parameter int NUM_MATCH = 4,
  parameter int CNT_W     = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cnt_en,
  input logic                            center,
  input logic [CNT_W-1:0]                period,
  input logic [CNT_W-1:0]                count,
  input logic [CNT_W-1:0]                tc_nxt,
  input logic                            step_down,
  input logic [NUM_MATCH-1:0][CNT_W-1:0] act,
  input logic [NUM_MATCH-1:0]            pwm
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R11: a stopped counter holds count and outputs.
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> ($stable(count) && $stable(pwm)));

  // R2: edge-aligned advance below the period.
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !center && (count < period)) |=> (count == $past(count) + ONE));

  // R2: edge-aligned wrap at the period.
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !center && (count >= period)) |=> (count == '0));

  // R9: center-aligned turn at the top without repeating it.
  a_r9_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && center && (period != '0) && (count == period)) |=> (count == $past(count) - ONE));

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_out
    // R3: each edge-aligned cycle starts LOW unless the match is zero.
    a_r3_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !center && (count >= period)) |=> (pwm[g] == (act[g] == '0)));

    // R10: on the downward leg the output is LOW at or below its match.
    a_r10_down_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && center && step_down && (tc_nxt != '0) && (tc_nxt <= act[g])) |=> !pwm[g]);
  end

endmodule

bind pwm_match_timer pwm_match_timer_chk #(
  .NUM_MATCH (NUM_MATCH),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .cnt_en    (cnt_en),
  .center    (center_q),
  .period    (period),
  .count     (count_o),
  .tc_nxt    (tc_nxt),
  .step_down (step_down),
  .act       (act_q),
  .pwm       (pwm_o)
);

// File: tb/sim_pwm_match_timer.sv
module sim_pwm_match_timer;

  localparam int NM = 4;
  localparam int W  = 32;

  logic          clk;
  logic          rst_n;
  logic          cnt_en;
  logic          match_we;
  logic [1:0]    match_sel;
  logic [W-1:0]  match_data;
  logic          ctrl_we;
  logic [NM-1:0] ctrl_period_mask;
  logic          ctrl_center;
  logic [W-1:0]  count_o;
  logic [NM-1:0] pwm_o;

  int n_chk;
  int n_bad;
  bit done;
  int cur_m [NM];

  pwm_match_timer #(.NUM_MATCH(NM), .CNT_W(W)) u0 (
    .clk              (clk),
    .rst_n            (rst_n),
    .cnt_en           (cnt_en),
    .match_we         (match_we),
    .match_sel        (match_sel),
    .match_data       (match_data),
    .ctrl_we          (ctrl_we),
    .ctrl_period_mask (ctrl_period_mask),
    .ctrl_center      (ctrl_center),
    .count_o          (count_o),
    .pwm_o            (pwm_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Expected level of one output from the requirements.
  function automatic logic exp_pwm(int m, int t, bit dn, bit at_start, bit seen);
    if (m == 0) return seen;      // R4
    if (at_start) return 1'b0;    // R3, R10
    if (dn) return (t > m);       // R10
    return (t >= m);              // R3, R5, R6
  endfunction

  function automatic string tag_for(int m, int p, bit center);
    if (m == 0) return "R4";
    if (center) return "R10";
    if (m == p) return "R5";
    if (m > p) return "R6";
    return "R3";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    cnt_en   = 1'b0;
    match_we = 1'b0;
    ctrl_we  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_match(int sel, int val);
    @(negedge clk);
    match_we   = 1'b1;
    match_sel  = 2'(sel);
    match_data = W'(val);
    @(negedge clk);
    match_we = 1'b0;
  endtask

  task automatic setup(logic [NM-1:0] mask, bit center, int m0, int m1, int m2, int m3);
    do_reset();
    @(negedge clk);
    ctrl_we          = 1'b1;
    ctrl_period_mask = mask;
    ctrl_center      = center;
    @(negedge clk);
    ctrl_we = 1'b0;
    wr_match(0, m0);
    wr_match(1, m1);
    wr_match(2, m2);
    wr_match(3, m3);
    cur_m[0] = m0;
    cur_m[1] = m1;
    cur_m[2] = m2;
    cur_m[3] = m3;
    cnt_en = 1'b1;
  endtask

  // Runs n enabled steps and checks count and every output after each.
  task automatic run_cycles(string ttag, int p, bit center, int n);
    int len;
    int s;
    int t;
    bit dn;
    len = center ? 2 * p : p + 1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      s  = k % len;
      dn = center && (s > p);
      t  = dn ? len - s : s;
      chk(ttag, count_o, W'(t));
      for (int c = 0; c < NM; c++) begin
        chk(tag_for(cur_m[c], p, center), W'(pwm_o[c]),
            W'(exp_pwm(cur_m[c], t, dn, s == 0, k >= len)));
      end
    end
  endtask

  task automatic t_reset();
    setup(4'b0001, 1'b0, 4, 2, 0, 1);
    run_cycles("R2", 4, 1'b0, 3);
    @(negedge clk);
    rst_n  = 1'b0;
    cnt_en = 1'b0;
    @(negedge clk);
    chk("R1", count_o, '0);
    chk("R1", W'(pwm_o), '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", count_o, '0);
    chk("R1", W'(pwm_o), '0);
  endtask

  task automatic t_up_basic();
    setup(4'b0001, 1'b0, 10, 3, 0, 12);
    run_cycles("R2", 10, 1'b0, 35);
    cnt_en = 1'b0;
  endtask

  task automatic t_center();
    setup(4'b0001, 1'b1, 6, 2, 0, 9);
    run_cycles("R9", 6, 1'b1, 30);
    cnt_en = 1'b0;
  endtask

  task automatic t_priority();
    // Registers 1 and 2 both marked: register 1 (value 8) sets the period.
    setup(4'b0110, 1'b0, 3, 8, 5, 0);
    run_cycles("R8", 8, 1'b0, 20);
    cnt_en = 1'b0;
  endtask

  task automatic t_shadow();
    setup(4'b0001, 1'b0, 10, 3, 0, 5);
    for (int k = 1; k <= 25; k++) begin
      int s;
      @(negedge clk);
      s = k % 11;
      if (k == 5) match_we = 1'b0;
      chk("R7", count_o, W'(s));
      // R7: the value written at step 4 is in force only from step 11.
      chk("R7", W'(pwm_o[1]), W'(exp_pwm((k >= 11) ? 7 : 3, s, 1'b0, s == 0, k >= 11)));
      if (k == 4) begin
        match_we   = 1'b1;
        match_sel  = 2'd1;
        match_data = W'(7);
      end
    end
    cnt_en = 1'b0;
  endtask

  task automatic t_freeze_oversize();
    logic [NM-1:0] held;
    setup(4'b0001, 1'b0, 10, 3, 0, 5);
    run_cycles("R2", 10, 1'b0, 5);
    held   = pwm_o;
    cnt_en = 1'b0;
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      chk("R11", count_o, W'(5));
      chk("R11", W'(pwm_o), W'(4'b1010));
      chk("R11", W'(pwm_o), W'(held));
      if (j == 2) begin
        match_we   = 1'b1;
        match_sel  = 2'd1;
        match_data = W'(50);
      end
      if (j == 3) match_we = 1'b0;
    end
    cnt_en = 1'b1;
    for (int k = 6; k <= 21; k++) begin
      @(negedge clk);
      chk("R2", count_o, W'(k % 11));
      // R6: HIGH output keeps going to the end of the cycle, then stays LOW.
      chk("R6", W'(pwm_o[1]), W'((k <= 10) ? 1 : 0));
    end
    cnt_en = 1'b0;
  endtask

  initial begin
    n_chk            = 0;
    n_bad            = 0;
    done             = 1'b0;
    rst_n            = 1'b0;
    cnt_en           = 1'b0;
    match_we         = 1'b0;
    match_sel        = '0;
    match_data       = '0;
    ctrl_we          = 1'b0;
    ctrl_period_mask = '0;
    ctrl_center      = 1'b0;
    t_reset();
    t_up_basic();
    t_center();
    t_priority();
    t_shadow();
    t_freeze_oversize();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (R1..R11 run): actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule